// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 32-bit general-purpose I/O peripheral behind a simple word-addressed register slave port. Software sets each pin's direction. For each output pin it chooses between a software-written level and an auxiliary hardware signal. Software can read back the sampled pin levels. Pins are sampled and outputs are updated on a sampling tick. The tick comes every system clock, or from a chosen edge of an external clock that the block synchronizes into its own domain.

Each pin can be set to raise an event on a rising or a falling transition. Enabled events set sticky per-pin flags and a pending flag in the control register. The interrupt output follows that pending flag. Software acknowledges an interrupt by rewriting the flag registers.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero, and `irq` is low.
- R2: Registers sit at byte offsets 0x00 input, 0x04 output, 0x08 direction (1 = output), 0x0C event mask, 0x10 edge select, 0x14 auxiliary select, 0x18 control, 0x1C event flags. A read request puts the addressed value on `bus_rdata` at the next clock edge. In any other cycle `bus_rdata` is zero.
- R3: An access whose address is not a multiple of four, or that lies at or above 0x20, changes no register, and a read of such an address returns zero.
- R4: Writes to the input register have no effect. Reading it returns the sampled inputs ORed with the output register.
- R5: On every sampling tick the sampled input keeps only the bits whose direction bit is 0.
- R6: On every sampling tick `pad_out` becomes `alt_in` on bits whose auxiliary-select bit is 1 and the output register on the others, ANDed with the direction register. `pad_oe` always equals the direction register.
- R7: An edge-select bit of 1 makes a 0-to-1 transition of the sampled input an event. A bit of 0 makes a 1-to-0 transition an event.
- R8: Events are recognised only while control bit 2 is 1, and only on pins whose mask bit is 1.
- R9: Any recognised event sets control bit 3, and `irq` equals control bit 3. Event bits are ORed into the flag register and stay set. An event in the same cycle as a software write to the flags or control register still lands on top of the written value.
- R10: With control bit 0 set, a tick comes only on a synchronized edge of `ext_clk`: the rising edge, or the falling edge when control bit 1 is also set. Without ticks the sampled inputs and `pad_out` hold.
- R11: Writing the flag register or the control register replaces its contents, so writing zeros acknowledges events and lowers `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| ext_clk | input | 1 | Optional external sampling clock |
| pad_in | input | DATA_W | Pin input levels |
| alt_in | input | DATA_W | Auxiliary output sources |
| pad_out | output | DATA_W | Registered pin output levels |
| pad_oe | output | DATA_W | Pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives both edge polarities on a mix of masked and unmasked pins. A swapped polarity term or an ignored mask would then flag the wrong pins or the wrong number of them. It also lets an event coincide with a software clear of the flags. A design that let the write win there would silently lose that event. Accesses at misaligned and just-out-of-window addresses are included, and a decoder that truncates the address would alias them onto real registers. In external-clock mode the bench holds the clock level steady and checks that nothing moves, then toggles it with the opposite polarity selected. A design that ticks on any edge or keeps ticking on the system clock would sample too early.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [2:0] {
    REG_PIN_IN   = 3'd0,
    REG_PIN_OUT  = 3'd1,
    REG_DIR      = 3'd2,
    REG_EV_MASK  = 3'd3,
    REG_EDGE_SEL = 3'd4,
    REG_ALT_SEL  = 3'd5,
    REG_CFG      = 3'd6,
    REG_EV_FLAGS = 3'd7
  } reg_idx_e;

  localparam int CFG_EXT_CLK = 0;
  localparam int CFG_FALL    = 1;
  localparam int CFG_IEN     = 2;
  localparam int CFG_PEND    = 3;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_ok,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    addr_ok = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:IDX_W+2] == '0);
    idx     = addr[IDX_W+1:2];
  end
endmodule

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic use_ext,
  input  logic fall_sel,
  output logic tick
);
  logic [SYNC_STAGES:0] sh_q;
  logic cur_lvl, prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk};
  end

  always_comb begin
    cur_lvl  = sh_q[SYNC_STAGES-1];
    prev_lvl = sh_q[SYNC_STAGES];
    if (!use_ext)      tick = 1'b1;
    else if (fall_sel) tick = prev_lvl & ~cur_lvl;
    else               tick = cur_lvl & ~prev_lvl;
  end

  // R10
  ext_tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (use_ext && tick) |=> (!tick || !use_ext));
endmodule

// File: rtl/gpio_pin_core.sv
module gpio_pin_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ien,
  input  logic [DATA_W-1:0] pad_in,
  input  logic [DATA_W-1:0] alt_in,
  input  logic [DATA_W-1:0] dir,
  input  logic [DATA_W-1:0] alt_sel,
  input  logic [DATA_W-1:0] out_reg,
  input  logic [DATA_W-1:0] edge_sel,
  input  logic [DATA_W-1:0] ev_mask,
  output logic [DATA_W-1:0] in_s,
  output logic [DATA_W-1:0] drv,
  output logic [DATA_W-1:0] hit_bits
);
  logic [DATA_W-1:0] nxt_in, rise, fall, chosen;

  always_comb begin
    nxt_in   = pad_in & ~dir;
    rise     = nxt_in & ~in_s;
    fall     = ~nxt_in & in_s;
    chosen   = (edge_sel & rise) | (~edge_sel & fall);
    hit_bits = (tick && ien) ? (chosen & ev_mask) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_s <= '0;
      drv  <= '0;
    end else if (tick) begin
      in_s <= nxt_in;
      drv  <= ((out_reg & ~alt_sel) | (alt_in & alt_sel)) & dir;
    end
  end

  // R5
  in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((in_s & $past(dir)) == '0));
  // R6
  drv_mask_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((drv & ~$past(dir)) == '0));
  // R10
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(in_s) && $stable(drv)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  input  logic [DATA_W-1:0] pad_in,
  input  logic [DATA_W-1:0] alt_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  output logic              irq
);
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic              addr_ok, wr, rd, wr_cfg, wr_flags, tick;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] out_q, dir_q, mask_q, edge_q, alt_q, cfg_q, flags_q;
  logic [DATA_W-1:0] cfg_nxt, flags_nxt, in_s, drv, hit_bits, rd_mux;

  gpio_bus_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .addr_ok(addr_ok), .idx(idx)
  );

  gpio_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .ext_clk(ext_clk),
    .use_ext(cfg_q[CFG_EXT_CLK]), .fall_sel(cfg_q[CFG_FALL]), .tick(tick)
  );

  gpio_pin_core #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .tick(tick), .ien(cfg_q[CFG_IEN]),
    .pad_in(pad_in), .alt_in(alt_in), .dir(dir_q), .alt_sel(alt_q),
    .out_reg(out_q), .edge_sel(edge_q), .ev_mask(mask_q),
    .in_s(in_s), .drv(drv), .hit_bits(hit_bits)
  );

  always_comb begin
    wr       = bus_sel && bus_we && addr_ok;
    rd       = bus_sel && !bus_we && addr_ok;
    wr_cfg   = wr && (idx == REG_CFG);
    wr_flags = wr && (idx == REG_EV_FLAGS);
    cfg_nxt  = wr_cfg ? bus_wdata : cfg_q;
    if (|hit_bits) cfg_nxt[CFG_PEND] = 1'b1;
    flags_nxt = (wr_flags ? bus_wdata : flags_q) | hit_bits;
    case (idx)
      REG_PIN_IN:   rd_mux = in_s | out_q;
      REG_PIN_OUT:  rd_mux = out_q;
      REG_DIR:      rd_mux = dir_q;
      REG_EV_MASK:  rd_mux = mask_q;
      REG_EDGE_SEL: rd_mux = edge_q;
      REG_ALT_SEL:  rd_mux = alt_q;
      REG_CFG:      rd_mux = cfg_q;
      default:      rd_mux = flags_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= '0;
      dir_q     <= '0;
      mask_q    <= '0;
      edge_q    <= '0;
      alt_q     <= '0;
      cfg_q     <= '0;
      flags_q   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr) begin
        case (idx)
          REG_PIN_OUT:  out_q  <= bus_wdata;
          REG_DIR:      dir_q  <= bus_wdata;
          REG_EV_MASK:  mask_q <= bus_wdata;
          REG_EDGE_SEL: edge_q <= bus_wdata;
          REG_ALT_SEL:  alt_q  <= bus_wdata;
          default: ;
        endcase
      end
      cfg_q     <= cfg_nxt;
      flags_q   <= flags_nxt;
      bus_rdata <= rd ? rd_mux : '0;
    end
  end

  assign pad_out = drv;
  assign pad_oe  = dir_q;
  assign irq     = cfg_q[CFG_PEND];

  // R9
  pend_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit_bits) |=> irq);
  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R3
  bad_access_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !addr_ok) |=> (bus_rdata == '0 && $stable(out_q) && $stable(dir_q)));
endmodule

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0, rst = 1'b1;
  logic          bus_sel = 1'b0, bus_we = 1'b0, ext_clk = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, pad_in = '0, alt_in = '0;
  logic [DW-1:0] bus_rdata, pad_out, pad_oe;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_issued = 1'b0;

  gpio_edge_ctrl dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .pad_in(pad_in), .alt_in(alt_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: notes a read at the edge, compares rdata at the following negedge
  always @(posedge clk) rd_issued <= bus_sel && !bus_we;
  always @(negedge clk) begin
    if (rd_issued) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr_with_pad(logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] p);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; pad_in = p;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    for (int r = 0; r < 8; r++) bus_rd(AW'(r * 4), 0, "R1 reg after reset");
    chk("R2 rdata idle zero", bus_rdata, 0);

    // R2 map and read-back
    bus_wr(8'h04, 32'hA5A5_0F0F); bus_rd(8'h04, 32'hA5A5_0F0F, "R2 output reg");
    bus_wr(8'h08, 32'hF000_0000); bus_rd(8'h08, 32'hF000_0000, "R2 direction reg");
    bus_wr(8'h0C, 32'h0000_FFFF); bus_rd(8'h0C, 32'h0000_FFFF, "R2 mask reg");
    bus_wr(8'h10, 32'h1234_5678); bus_rd(8'h10, 32'h1234_5678, "R2 edge reg");
    bus_wr(8'h14, 32'h8000_0001); bus_rd(8'h14, 32'h8000_0001, "R2 aux reg");
    // R3 bad addresses
    bus_wr(8'h24, 32'hDEAD_BEEF); bus_wr(8'h05, 32'h0BAD_F00D);
    bus_rd(8'h04, 32'hA5A5_0F0F, "R3 output reg untouched");
    bus_rd(8'h24, 0, "R3 out-of-window read");
    bus_rd(8'h06, 0, "R3 misaligned read");
    for (int r = 1; r < 6; r++) bus_wr(AW'(r * 4), 0);

    // R4 input register
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, 0, "R4 input write ignored");
    pad_in = 32'h0000_1234; bus_wr(8'h04, 32'h00FF_0000);
    bus_rd(8'h00, 32'h00FF_1234, "R4 input read ORs output reg");
    bus_wr(8'h04, 0);

    // R5 direction masks samples
    bus_wr(8'h08, 32'h0000_FFFF); pad_in = 32'hFFFF_FFFF; idle(2);
    bus_rd(8'h00, 32'hFFFF_0000, "R5 input masked by direction");

    // R6 output mux
    alt_in = 32'hCAFE_BABE;
    bus_wr(8'h04, 32'h1234_5678); bus_wr(8'h14, 32'h0000_00FF); idle(2);
    chk("R6 pad_out mux", pad_out, 32'h0000_56BE);
    chk("R6 pad_oe", pad_oe, 32'h0000_FFFF);
    bus_wr(8'h04, 0); bus_wr(8'h08, 0); bus_wr(8'h14, 0); idle(2);
    chk("R6 pad_out cleared", pad_out, 0);

    // R8 global enable off
    pad_in = 0; idle(2);
    bus_wr(8'h0C, 32'h0000_000F); bus_wr(8'h10, 32'h0000_0005);
    pad_in = 32'h0000_00FF; idle(2);
    chk("R8 no irq when disabled", {31'd0, irq}, 0);
    bus_rd(8'h1C, 0, "R8 no flags when disabled");
    // R7 falling on bits 1,3 only
    bus_wr(8'h18, 32'h4);
    pad_in = 0; idle(2);
    chk("R7 irq on falling", {31'd0, irq}, 1);
    bus_rd(8'h1C, 32'h0000_000A, "R7 falling flags");
    bus_rd(8'h18, 32'h0000_000C, "R9 pending flag");
    // R11 clear
    bus_wr(8'h1C, 0); bus_wr(8'h18, 32'h4); idle(1);
    chk("R11 irq cleared", {31'd0, irq}, 0);
    bus_rd(8'h1C, 0, "R11 flags cleared");
    // R7 rising on bits 0,2; R8 bits 4..7 masked
    pad_in = 32'h0000_00FF; idle(2);
    bus_rd(8'h1C, 32'h0000_0005, "R7 rising flags");
    pad_in = 0; idle(2);
    bus_rd(8'h1C, 32'h0000_000F, "R9 flags accumulate");
    // R9 event beats same-cycle clear
    wr_with_pad(8'h1C, 0, 32'h0000_0001);
    bus_rd(8'h1C, 32'h0000_0001, "R9 event over write");
    chk("R9 irq held", {31'd0, irq}, 1);

    // R10 external clock, rising
    bus_wr(8'h1C, 0); bus_wr(8'h18, 32'h1);
    pad_in = 32'h0000_0F00; idle(5);
    bus_rd(8'h00, 32'h0000_0001, "R10 hold without ext edge");
    ext_clk = 1'b1; idle(5);
    bus_rd(8'h00, 32'h0000_0F00, "R10 rising ext edge samples");
    // R10 falling select
    bus_wr(8'h18, 32'h3);
    pad_in = 32'h0000_00F0; idle(5);
    bus_rd(8'h00, 32'h0000_0F00, "R10 hold while ext high");
    ext_clk = 1'b0; idle(5);
    bus_rd(8'h00, 32'h0000_00F0, "R10 falling ext edge samples");

    idle(3);
    if (exp_q.size() != 0) chk("scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule